// File: doc/BRIEF.md
# Serial Flash Write-Enable and Whole-Array Erase Command Slave

This block is the device-side command logic for the erase path of a serial flash part. A host drives a serial clock, an active-low select and one data line. The block oversamples these pins with the system clock. It takes in one opcode per select window, most significant bit first, on each rising serial clock edge. It keeps a write-enable latch and a write-in-progress flag. When the host releases the select line, the block decides whether the byte it received is a command that it must act on.

A whole-array erase is committed only when four conditions hold. The select line must rise after exactly eight bits. The write-enable latch must be set. All three protect bits must be zero. No erase may already be running. The memory array itself is not modelled. A committed erase raises a one-cycle start pulse and runs a self-timed counter of a fixed number of system clocks. A one-cycle done pulse marks the end of the erase. While the erase runs, only the status-read opcode is served. Status is sent out on the falling serial clock edges and repeats for as long as select stays low.

Top module: `flash_erase_slave`

## Requirements
- R1: Opcode C7h starts an erase only if the write-enable latch is set. After reset the latch is clear, so an erase with no prior 06h produces no erase_start.
- R2: While cs_n is low, sdi is sampled on each rising sclk edge, most significant bit first. The bit count restarts each time cs_n goes high.
- R3: C7h is committed only when cs_n rises after exactly 8 sclk rising edges. With 1 to 7 edges, or with 9 or more, nothing starts and the status is unchanged.
- R4: A committed erase gives a one-cycle erase_start pulse. erase_done pulses for one cycle exactly T_BE system clocks later. The two pulses never coincide.
- R5: If protect_bits is not 000, C7h is ignored: no erase_start, and the write-enable latch is kept.
- R6: The status byte has bit 0 = write-in-progress, bit 1 = write-enable latch, bits 4:2 = protect_bits, and bits 7:5 = 0. After opcode 05h, sdo shifts it out MSB first and changes after each falling sclk edge. It repeats while cs_n stays low, and sdo is 0 otherwise.
- R7: Write-in-progress reads 1 from erase_start until the erase ends, and reads 0 afterwards.
- R8: The write-enable latch is cleared on the final count of the erase, so it reads 0 when erase_done is seen.
- R9: While an erase is running, every opcode except 05h is ignored. A second C7h gives no erase_start.
- R10: Opcode 06h sets the write-enable latch only when cs_n rises after exactly 8 bits. All other opcodes, and 06h with a wrong bit count, leave the latch unchanged.
- R11: After the synchronous reset, sdo, erase_start and erase_done are 0, and the status reads 00h with protect_bits at 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low select; a low window frames one command |
| sdi | input | 1 | Serial opcode input |
| protect_bits | input | 3 | Block-protect setting; any nonzero value blocks the erase |
| sdo | output | 1 | Serial status output |
| erase_start | output | 1 | One-cycle pulse when an erase is committed |
| erase_done | output | 1 | One-cycle pulse when the erase cycle ends |

## Verification
The hardest case to reach from the ports is a status read that lands inside a running erase. The bench sets T_BE long enough that a complete command and a complete one-byte read both fit inside the erase window. It commits an erase, sends a second erase, and reads the status byte, all before erase_done. The select-release boundary is covered by sweeping the number of clocked bits from 1 to 12 around the eight-bit point. The protect bits are swept over all nonzero values, and every one of the 256 opcodes is issued after a write enable.

// File: rtl/fes_pkg.sv
package fes_pkg;

    localparam int OP_W     = 8;
    localparam int PROT_W   = 3;
    localparam int BITCNT_W = $clog2(2 * OP_W);
    localparam int PTR_W    = $clog2(OP_W);

    localparam logic [OP_W-1:0] OPC_WRITE_EN = 8'h06;
    localparam logic [OP_W-1:0] OPC_ERASE_ALL = 8'hC7;
    localparam logic [OP_W-1:0] OPC_READ_STAT = 8'h05;

    typedef struct packed {
        logic [OP_W-PROT_W-3:0] spare;
        logic [PROT_W-1:0]      prot;
        logic                   wel;
        logic                   wip;
    } status_t;

    typedef enum logic [1:0] {
        CMD_OTHER,
        CMD_WREN,
        CMD_ERASE,
        CMD_RDSR
    } cmd_e;

    typedef struct packed {
        logic cs_active;
        logic cs_rise;
        logic sclk_rise;
        logic sclk_fall;
        logic sdi;
    } serial_ev_t;

    function automatic cmd_e decode_op(input logic [OP_W-1:0] op);
        case (op)
            OPC_WRITE_EN:  return CMD_WREN;
            OPC_ERASE_ALL: return CMD_ERASE;
            OPC_READ_STAT: return CMD_RDSR;
            default:       return CMD_OTHER;
        endcase
    endfunction

    function automatic status_t make_status(input logic wip, input logic wel,
                                            input logic [PROT_W-1:0] prot);
        status_t s;
        s.spare = '0;
        s.prot  = prot;
        s.wel   = wel;
        s.wip   = wip;
        return s;
    endfunction

endpackage

// File: rtl/fes_sampler.sv
module fes_sampler
    import fes_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       sdi,
    output serial_ev_t ev
);

    localparam int HIST = SYNC_STAGES + 1;

    logic [HIST-1:0]        sclk_h;
    logic [HIST-1:0]        cs_h;
    logic [SYNC_STAGES-1:0] sdi_h;

    // One register stage per history slot; slot 0 takes the raw pin.
    generate
        for (genvar i = 0; i < HIST; i++) begin : g_hist
            always_ff @(posedge clk) begin
                if (rst) begin
                    sclk_h[i] <= 1'b0;
                    cs_h[i]   <= 1'b1;
                end else if (i == 0) begin
                    sclk_h[i] <= sclk;
                    cs_h[i]   <= cs_n;
                end else begin
                    sclk_h[i] <= sclk_h[(i > 0) ? i - 1 : 0];
                    cs_h[i]   <= cs_h[(i > 0) ? i - 1 : 0];
                end
            end
        end
        for (genvar j = 0; j < SYNC_STAGES; j++) begin : g_data
            always_ff @(posedge clk) begin
                if (rst)         sdi_h[j] <= 1'b0;
                else if (j == 0) sdi_h[j] <= sdi;
                else             sdi_h[j] <= sdi_h[(j > 0) ? j - 1 : 0];
            end
        end
    endgenerate

    always_comb begin
        ev.cs_active = !cs_h[SYNC_STAGES-1];
        ev.cs_rise   = cs_h[SYNC_STAGES-1] && !cs_h[SYNC_STAGES];
        ev.sclk_rise = ev.cs_active && sclk_h[SYNC_STAGES-1] && !sclk_h[SYNC_STAGES];
        ev.sclk_fall = ev.cs_active && !sclk_h[SYNC_STAGES-1] && sclk_h[SYNC_STAGES];
        ev.sdi       = sdi_h[SYNC_STAGES-1];
    end

endmodule

// File: rtl/fes_shifter.sv
module fes_shifter
    import fes_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_active,
    input  logic            sclk_rise,
    input  logic            sclk_fall,
    input  logic            sdi_bit,
    input  status_t         status,
    output logic [OP_W-1:0] opcode,
    output logic            on_boundary,
    output logic            sdo
);

    localparam logic [BITCNT_W-1:0] CNT_MAX  = '1;
    localparam logic [BITCNT_W-1:0] CNT_LAST = BITCNT_W'(OP_W - 1);
    localparam logic [PTR_W-1:0]    PTR_TOP  = PTR_W'(OP_W - 1);

    logic [BITCNT_W-1:0] bit_cnt;
    logic [OP_W-1:0]     shreg;
    logic [OP_W-1:0]     next_byte;
    logic                rd_mode;
    logic [PTR_W-1:0]    ptr;
    status_t             snap;

    assign next_byte   = {shreg[OP_W-2:0], sdi_bit};
    assign opcode      = shreg;
    assign on_boundary = (bit_cnt == BITCNT_W'(OP_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shreg   <= '0;
            rd_mode <= 1'b0;
            ptr     <= PTR_TOP;
            snap    <= '0;
            sdo     <= 1'b0;
        end else if (!cs_active) begin
            bit_cnt <= '0;
            rd_mode <= 1'b0;
            ptr     <= PTR_TOP;
            sdo     <= 1'b0;
        end else begin
            if (sclk_rise) begin
                shreg <= next_byte;
                if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_LAST && decode_op(next_byte) == CMD_RDSR)
                    rd_mode <= 1'b1;
            end
            if (sclk_fall && rd_mode) begin
                // Take a fresh status image at the start of every byte.
                if (ptr == PTR_TOP) begin
                    snap <= status;
                    sdo  <= status[OP_W-1];
                end else begin
                    sdo  <= snap[ptr];
                end
                ptr <= ptr - 1'b1;
            end
        end
    end

endmodule

// File: rtl/fes_erase_timer.sv
module fes_erase_timer #(
    parameter int T_BE  = 1000,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             finish,
    output logic             done,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(T_BE - 1);

    assign finish = busy && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= finish;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (finish) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (busy) begin
                cnt  <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_erase_slave.sv
module flash_erase_slave
    import fes_pkg::*;
#(
    parameter int T_BE        = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic [PROT_W-1:0] protect_bits,
    output logic              sdo,
    output logic              erase_start,
    output logic              erase_done
);

    localparam int TCNT_W = (T_BE > 1) ? $clog2(T_BE) : 1;

    serial_ev_t        ev;
    status_t           status;
    logic [OP_W-1:0]   opcode;
    logic              on_boundary;
    logic              wel;
    logic              busy;
    logic              finish;
    logic [TCNT_W-1:0] tmr_cnt;
    cmd_e              cmd;
    logic              cmd_ok;
    logic              wren_go;
    logic              erase_go;

    fes_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .cs_n (cs_n),
        .sdi  (sdi),
        .ev   (ev)
    );

    fes_shifter u_shifter (
        .clk         (clk),
        .rst         (rst),
        .cs_active   (ev.cs_active),
        .sclk_rise   (ev.sclk_rise),
        .sclk_fall   (ev.sclk_fall),
        .sdi_bit     (ev.sdi),
        .status      (status),
        .opcode      (opcode),
        .on_boundary (on_boundary),
        .sdo         (sdo)
    );

    fes_erase_timer #(.T_BE(T_BE), .CNT_W(TCNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (erase_go),
        .busy   (busy),
        .finish (finish),
        .done   (erase_done),
        .cnt    (tmr_cnt)
    );

    // Commands act only on select release at a clean byte edge, outside an erase.
    assign cmd      = decode_op(opcode);
    assign cmd_ok   = ev.cs_rise && on_boundary && !busy;
    assign wren_go  = cmd_ok && (cmd == CMD_WREN);
    assign erase_go = cmd_ok && (cmd == CMD_ERASE) && wel && (protect_bits == '0);
    assign status   = make_status(busy, wel, protect_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            wel         <= 1'b0;
            erase_start <= 1'b0;
        end else begin
            erase_start <= erase_go;
            if (finish)       wel <= 1'b0;
            else if (wren_go) wel <= 1'b1;
        end
    end

endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
    parameter int T_BE   = 1000,
    parameter int TCNT_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        protect_bits,
    input logic              erase_start,
    input logic              erase_done,
    input logic              busy,
    input logic              wel,
    input logic [TCNT_W-1:0] tmr_cnt
);

    p_start_needs_wel_r1: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> $past(wel));

    p_start_unprotected_r5: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> ($past(protect_bits) == 3'b000));

    p_start_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> !$past(busy));

    p_busy_with_start_r7: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> busy);

    p_done_clears_wel_r8: assert property (@(posedge clk) disable iff (rst)
        erase_done |-> (!busy && !wel));

    p_end_gives_done_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> erase_done);

    p_count_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (32'(tmr_cnt) < T_BE));

    p_pulses_apart_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({erase_start, erase_done}));

endmodule

bind flash_erase_slave fes_checker #(.T_BE(T_BE), .TCNT_W(TCNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .protect_bits (protect_bits),
    .erase_start  (erase_start),
    .erase_done   (erase_done),
    .busy         (busy),
    .wel          (wel),
    .tmr_cnt      (tmr_cnt)
);

// File: tb/tb_flash_erase_slave.sv
module tb_flash_erase_slave;

    localparam int T_BE = 400;
    localparam int HP   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic [2:0] prot = 3'b000;
    logic       sdo;
    logic       erase_start;
    logic       erase_done;

    int n_checks = 0;
    int n_err    = 0;
    int n_start  = 0;
    int n_done   = 0;
    int cyc      = 0;
    int t_start  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flash_erase_slave #(.T_BE(T_BE)) dut (
        .clk          (clk),
        .rst          (rst),
        .sclk         (sclk),
        .cs_n         (cs_n),
        .sdi          (sdi),
        .protect_bits (prot),
        .sdo          (sdo),
        .erase_start  (erase_start),
        .erase_done   (erase_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R4: erase_done follows erase_start by exactly T_BE cycles
    always @(negedge clk) begin
        cyc++;
        if (!rst && erase_start) begin
            n_start++;
            t_start = cyc;
        end
        if (!rst && erase_done) begin
            n_done++;
            chk((cyc - t_start) == T_BE, "R4 erase length", cyc - t_start, T_BE);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_stat(input bit wip, input bit wel, input logic [2:0] p);
        return {3'b000, p, wel, wip};
    endfunction

    task automatic xfer(input logic [7:0] op, input int nbits, input int rdbytes,
                        output logic [7:0] rd, output bit same);
        logic [7:0] cur;
        cs_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 8) ? op[7 - i] : 1'b0;
            tick(HP);
            sclk = 1'b1;
            tick(HP);
            sclk = 1'b0;
        end
        same = 1'b1;
        rd   = 8'h00;
        for (int b = 0; b < rdbytes; b++) begin
            cur = 8'h00;
            for (int i = 0; i < 8; i++) begin
                sdi = 1'b0;
                tick(HP);
                cur = {cur[6:0], sdo};
                sclk = 1'b1;
                tick(HP);
                sclk = 1'b0;
            end
            if (b == 0) rd = cur;
            else if (cur != rd) same = 1'b0;
        end
        tick(HP);
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic cmd(input logic [7:0] op, input int nbits);
        logic [7:0] d;
        bit s;
        xfer(op, nbits, 0, d, s);
    endtask

    task automatic rdsr(output logic [7:0] v);
        bit s;
        xfer(8'h05, 8, 1, v, s);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (n_done < n_start && guard < 4 * T_BE) begin
            tick(1);
            guard++;
        end
    endtask

    initial begin
        logic [7:0] st;
        logic [7:0] rd;
        bit         same;
        int         s0;

        tick(5);
        rst = 1'b0;
        tick(3);

        // R11: reset state
        chk(sdo == 1'b0, "R11 sdo after reset", sdo, 0);
        chk(erase_start == 1'b0 && erase_done == 1'b0, "R11 pulses after reset",
            {erase_start, erase_done}, 0);
        rdsr(st);
        chk(st == exp_stat(0, 0, 3'b000), "R11 status after reset", st, 0);

        // R1: erase without prior write enable
        cmd(8'hC7, 8);
        chk(n_start == 0, "R1 erase needs latch", n_start, 0);
        rdsr(st);
        chk(st == 8'h00, "R1 status unchanged", st, 0);

        // R10: write enable with wrong bit counts leaves latch clear
        for (int n = 7; n <= 9; n += 2) begin
            cmd(8'h06, n);
            rdsr(st);
            chk(st == 8'h00, "R10 wren off boundary", st, 0);
        end
        cmd(8'h06, 8);
        rdsr(st);
        chk(st == exp_stat(0, 1, 3'b000), "R10 wren sets latch", st, 8'h02);

        // R5/R6: every nonzero protect value blocks the erase and shows in bits 4:2
        for (int p = 1; p < 8; p++) begin
            prot = 3'(p);
            cmd(8'hC7, 8);
            rdsr(st);
            chk(n_start == 0, "R5 protected erase ignored", n_start, 0);
            chk(st == exp_stat(0, 1, 3'(p)), "R6 R5 status with protect", st,
                exp_stat(0, 1, 3'(p)));
        end

        // R6: status repeats while select stays low; sdo idles at 0 afterwards
        prot = 3'b101;
        xfer(8'h05, 8, 3, rd, same);
        chk(rd == exp_stat(0, 1, 3'b101), "R6 repeated status value", rd, 8'h16);
        chk(same, "R6 status repeats each byte", same, 1);
        chk(sdo == 1'b0, "R6 sdo idle after read", sdo, 0);
        prot = 3'b000;

        // R3: select release at any count other than eight discards the erase
        for (int n = 1; n <= 12; n++) begin
            if (n != 8) begin
                cmd(8'hC7, n);
                chk(n_start == 0, "R3 erase off boundary", n_start, 0);
            end
        end
        rdsr(st);
        chk(st == 8'h02, "R3 status after discarded erases", st, 8'h02);

        // R3/R7/R9: committed erase, second erase while busy, status during erase
        cmd(8'hC7, 8);
        chk(n_start == 1, "R3 erase on boundary", n_start, 1);
        cmd(8'hC7, 8);
        chk(n_start == 1, "R9 erase ignored while busy", n_start, 1);
        rdsr(st);
        chk(n_done == 0, "R7 read fell inside erase", n_done, 0);
        chk(st == exp_stat(1, 1, 3'b000), "R7 wip set during erase", st, 8'h03);
        wait_idle();
        chk(n_done == 1, "R4 erase finished", n_done, 1);
        rdsr(st);
        chk(st == 8'h00, "R7 R8 wip and latch clear after erase", st, 0);

        // R2/R10: every opcode after a write enable
        for (int op = 0; op < 256; op++) begin
            cmd(8'h06, 8);
            s0 = n_start;
            cmd(8'(op), 8);
            if (op == 8'hC7) begin
                chk(n_start == s0 + 1, "R2 erase opcode decoded", n_start, s0 + 1);
                wait_idle();
                rdsr(st);
                chk(st == 8'h00, "R8 latch clear after sweep erase", st, 0);
            end else begin
                chk(n_start == s0, "R2 no erase for other opcode", n_start, s0);
                rdsr(st);
                chk(st == 8'h02, "R10 latch kept by other opcode", st, 8'h02);
            end
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule